// File: doc/BRIEF.md
# MSI capture FIFO controller

This block sits beside the inbound write path of a PCIe root port. Every inbound memory write is checked against a programmable address window. A write that falls inside the window while capture is switched on is treated as a message-signalled interrupt. Its 32-bit data word and 64-bit target address are stored in a hardware FIFO, and the write is not forwarded. All other writes leave on the pass-through port unchanged, in the same cycle.

Software drains the FIFO through a 32-bit APB register slave with no wait states. It reads the head entry's data word, low address word and high address word, in any order. The entry is removed only when all three have been read. A sender signals vector n by writing the value n to window base + 4·n, so the data word names the vector.

One level interrupt line combines the message source with four legacy INTx inputs. It is gated by a combined enable register and a write-1-to-clear status register.

Top module: `msi_capture_ctrl`

## Requirements
- R1: An inbound write is captured when base ≤ address < base + size, using the 64-bit base from registers 0x04 (low word) and 0x08 (high word) and the byte size from 0x0C. Any write that is not captured appears on pass_valid/pass_addr/pass_data in the same cycle, unchanged. A captured write never appears there.
- R2: Capture happens only while bit 0 of the enable register (0x14) is 1. When that bit is 0, every write is passed through.
- R3: Captured messages leave the FIFO in arrival order. The head's data word reads at 0x20, its address bits 31:0 at 0x24 and its address bits 63:32 at 0x28.
- R4: Status register 0x18 bit 0 reads 1 exactly while the FIFO holds at least one entry.
- R5: The head entry is removed in the cycle that completes reads of all three head fields, in any order. Until then, status bit 0 stays set and a repeated read of a field returns the same value.
- R6: A message that arrives while the FIFO already holds FIFO_DEPTH entries is dropped, and the stored entries are kept. The drop sets a sticky overflow flag at status bit 1, which is cleared by writing 1 to that bit.
- R7: While the FIFO is empty, reads of 0x20, 0x24 and 0x28 return zero and count toward no later removal.
- R8: In the combined interrupt status register 0x34, bit 3 sets while the FIFO is non-empty, and bit 5+i sets while intx_in[i] is high. Writing 1 to a bit clears it. The bit sets again on the next cycle if its source is still active.
- R9: irq_out is the OR of the status bits in 0x34 that are also set in the enable register 0x30. Only bits 3 and 5 to 8 of 0x30 are writable; the others read 0.
- R10: Registers 0x04, 0x08, 0x0C and 0x14 (bit 0 only) read back what was last written to them. All of them reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound write valid |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| pass_valid | output | 1 | Forwarded write valid (write was not captured) |
| pass_addr | output | 64 | Forwarded write address |
| pass_data | output | 32 | Forwarded write data |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | APB_AW (12) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| intx_in | input | NUM_INTX (4) | Legacy INTA..INTD levels |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The pass-through decision is combinational, so the bench samples pass_valid 1 ns after driving each write, before the capturing edge. A capture is visible in status bit 0 from the first APB access after that edge. An APB read takes effect on the edge that ends its access phase, so removal is checked by the status read that follows. The combined status sets one edge after its source changes, and irq_out follows it with no further delay. The bench therefore waits at least two cycles after each interrupt stimulus before sampling. Random bursts of vectors and out-of-window writes are compared against a queue model, with one of the six read orders chosen at random for each pop.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   typedef struct packed {
      logic [31:0] data;
      logic [63:0] addr;
   } msi_entry_t;

   localparam int ENTRY_W = $bits(msi_entry_t);

   // register byte offsets
   localparam logic [7:0] OFF_BASE_LO = 8'h04;
   localparam logic [7:0] OFF_BASE_HI = 8'h08;
   localparam logic [7:0] OFF_SIZE    = 8'h0C;
   localparam logic [7:0] OFF_ENABLE  = 8'h14;
   localparam logic [7:0] OFF_STATUS  = 8'h18;
   localparam logic [7:0] OFF_DATA    = 8'h20;
   localparam logic [7:0] OFF_ADDR_LO = 8'h24;
   localparam logic [7:0] OFF_ADDR_HI = 8'h28;
   localparam logic [7:0] OFF_IRQ_EN  = 8'h30;
   localparam logic [7:0] OFF_IRQ_ST  = 8'h34;

   // combined interrupt bit positions
   localparam int IRQ_MSI_BIT  = 3;
   localparam int IRQ_INTX_LSB = 5;

endpackage

// File: rtl/msi_window_decode.sv
module msi_window_decode #(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 32
) (
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [SIZE_W-1:0] win_size,
   output logic              capture,
   output logic              pass_valid
);

   logic [ADDR_W-1:0] offs;
   logic              in_range;

   initial begin
      if (SIZE_W > ADDR_W) $error("msi_window_decode: SIZE_W must not exceed ADDR_W");
   end

   // offset compare avoids an overflowing base+size sum
   assign offs     = in_addr - win_base;
   assign in_range = (in_addr >= win_base) && (offs < ADDR_W'(win_size));
   assign capture    = in_valid && win_en && in_range;
   assign pass_valid = in_valid && !capture;

endmodule

// File: rtl/msi_fifo.sv
module msi_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 96
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   initial begin
      if (DEPTH < 2) $error("msi_fifo: DEPTH must be at least 2");
      if ((DEPTH & (DEPTH - 1)) != 0) $error("msi_fifo: DEPTH must be a power of two");
   end

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   // a full FIFO refuses a push even if it pops in the same cycle
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
   import msi_cap_pkg::*;
#(
   parameter int APB_AW   = 12,
   parameter int NUM_INTX = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [APB_AW-1:0]   paddr,
   input  logic [31:0]         pwdata,
   output logic [31:0]         prdata,
   input  msi_entry_t          head,
   input  logic                fifo_empty,
   input  logic                fifo_full,
   input  logic                capture,
   input  logic [NUM_INTX-1:0] intx_in,
   output logic [63:0]         win_base,
   output logic [31:0]         win_size,
   output logic                win_en,
   output logic                pop,
   output logic                irq_out
);

   localparam int IRQ_TOP = IRQ_INTX_LSB + NUM_INTX - 1;

   logic        rd, wr;
   logic        sel_blo, sel_bhi, sel_size, sel_en, sel_stat;
   logic        sel_dat, sel_alo, sel_ahi, sel_ien, sel_ist;
   logic [2:0]  seen, rd_fld, seen_nxt;
   logic        ovf;
   logic [31:0] irq_en_q, irq_st_q, irq_src, irq_clr, en_mask;

   initial begin
      if (APB_AW < 8) $error("msi_regfile: APB_AW must be at least 8");
      if (IRQ_TOP > 31) $error("msi_regfile: NUM_INTX too large");
   end

   assign rd = psel && penable && !pwrite;
   assign wr = psel && penable && pwrite;

   assign sel_blo  = (paddr == APB_AW'(OFF_BASE_LO));
   assign sel_bhi  = (paddr == APB_AW'(OFF_BASE_HI));
   assign sel_size = (paddr == APB_AW'(OFF_SIZE));
   assign sel_en   = (paddr == APB_AW'(OFF_ENABLE));
   assign sel_stat = (paddr == APB_AW'(OFF_STATUS));
   assign sel_dat  = (paddr == APB_AW'(OFF_DATA));
   assign sel_alo  = (paddr == APB_AW'(OFF_ADDR_LO));
   assign sel_ahi  = (paddr == APB_AW'(OFF_ADDR_HI));
   assign sel_ien  = (paddr == APB_AW'(OFF_IRQ_EN));
   assign sel_ist  = (paddr == APB_AW'(OFF_IRQ_ST));

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_base <= '0;
         win_size <= '0;
         win_en   <= 1'b0;
      end else if (wr) begin
         if (sel_blo)  win_base[31:0]  <= pwdata;
         if (sel_bhi)  win_base[63:32] <= pwdata;
         if (sel_size) win_size        <= pwdata;
         if (sel_en)   win_en          <= pwdata[0];
      end
   end

   // ---------------- pop sequencing ----------------
   // one flag per head field: data, addr low, addr high
   assign rd_fld   = {rd && sel_ahi, rd && sel_alo, rd && sel_dat} & {3{!fifo_empty}};
   assign seen_nxt = seen | rd_fld;
   assign pop      = !fifo_empty && (&seen_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n)   seen <= '0;
      else if (pop) seen <= '0;
      else          seen <= seen_nxt;
   end

   // ---------------- overflow flag ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)                              ovf <= 1'b0;
      else if (capture && fifo_full)           ovf <= 1'b1;
      else if (wr && sel_stat && pwdata[1])    ovf <= 1'b0;
   end

   // ---------------- combined interrupt ----------------
   always_comb begin
      en_mask = '0;
      en_mask[IRQ_MSI_BIT] = 1'b1;
      en_mask[IRQ_TOP:IRQ_INTX_LSB] = '1;
   end

   always_comb begin
      irq_src = '0;
      irq_src[IRQ_MSI_BIT] = !fifo_empty;
   end

   // per-line legacy sources feed their own status bits
   genvar gi;
   generate
      for (gi = 0; gi < NUM_INTX; gi++) begin : g_intx
         always_ff @(posedge clk) begin
            if (!rst_n)                       irq_st_q[IRQ_INTX_LSB+gi] <= 1'b0;
            else if (irq_clr[IRQ_INTX_LSB+gi]) irq_st_q[IRQ_INTX_LSB+gi] <= 1'b0;
            else if (intx_in[gi])             irq_st_q[IRQ_INTX_LSB+gi] <= 1'b1;
         end
      end
      for (gi = 0; gi < 32; gi++) begin : g_unused
         if (gi != IRQ_MSI_BIT && (gi < IRQ_INTX_LSB || gi > IRQ_TOP)) begin : g_zero
            assign irq_st_q[gi] = 1'b0;
         end
      end
   endgenerate

   assign irq_clr = (wr && sel_ist) ? (pwdata & en_mask) : '0;

   // clear wins; the source re-sets the bit on the next edge
   always_ff @(posedge clk) begin
      if (!rst_n)                    irq_st_q[IRQ_MSI_BIT] <= 1'b0;
      else if (irq_clr[IRQ_MSI_BIT]) irq_st_q[IRQ_MSI_BIT] <= 1'b0;
      else if (irq_src[IRQ_MSI_BIT]) irq_st_q[IRQ_MSI_BIT] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              irq_en_q <= '0;
      else if (wr && sel_ien)  irq_en_q <= pwdata & en_mask;
   end

   assign irq_out = |(irq_st_q & irq_en_q);

   // ---------------- read mux ----------------
   always_comb begin
      prdata = '0;
      if (sel_blo)       prdata = win_base[31:0];
      else if (sel_bhi)  prdata = win_base[63:32];
      else if (sel_size) prdata = win_size;
      else if (sel_en)   prdata = {31'b0, win_en};
      else if (sel_stat) prdata = {30'b0, ovf, !fifo_empty};
      else if (sel_dat)  prdata = fifo_empty ? '0 : head.data;
      else if (sel_alo)  prdata = fifo_empty ? '0 : head.addr[31:0];
      else if (sel_ahi)  prdata = fifo_empty ? '0 : head.addr[63:32];
      else if (sel_ien)  prdata = irq_en_q;
      else if (sel_ist)  prdata = irq_st_q;
   end

   // R5
   pop_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (rd && (sel_dat || sel_alo || sel_ahi)));

   // R6
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(capture && fifo_full));

   // R8
   msi_stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_st_q[IRQ_MSI_BIT]) |-> $past(wr && sel_ist && pwdata[IRQ_MSI_BIT]));

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
   import msi_cap_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int APB_AW     = 12,
   parameter int NUM_INTX   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [63:0]         in_addr,
   input  logic [31:0]         in_data,
   output logic                pass_valid,
   output logic [63:0]         pass_addr,
   output logic [31:0]         pass_data,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [APB_AW-1:0]   paddr,
   input  logic [31:0]         pwdata,
   output logic [31:0]         prdata,
   input  logic [NUM_INTX-1:0] intx_in,
   output logic                irq_out
);

   localparam int CW = $clog2(FIFO_DEPTH + 1);

   logic        capture, win_en, pop, fifo_empty, fifo_full;
   logic [63:0] win_base;
   logic [31:0] win_size;
   logic [CW-1:0] fifo_count;
   msi_entry_t  new_entry, head;
   logic [ENTRY_W-1:0] head_bits;

   assign new_entry = '{data: in_data, addr: in_addr};
   assign head      = msi_entry_t'(head_bits);
   assign pass_addr = in_addr;
   assign pass_data = in_data;

   msi_window_decode #(.ADDR_W(64), .SIZE_W(32)) u_decode (
      .in_valid   (in_valid),
      .in_addr    (in_addr),
      .win_en     (win_en),
      .win_base   (win_base),
      .win_size   (win_size),
      .capture    (capture),
      .pass_valid (pass_valid)
   );

   msi_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (capture),
      .wdata (new_entry),
      .pop   (pop),
      .rdata (head_bits),
      .empty (fifo_empty),
      .full  (fifo_full),
      .count (fifo_count)
   );

   msi_regfile #(.APB_AW(APB_AW), .NUM_INTX(NUM_INTX)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .psel       (psel),
      .penable    (penable),
      .pwrite     (pwrite),
      .paddr      (paddr),
      .pwdata     (pwdata),
      .prdata     (prdata),
      .head       (head),
      .fifo_empty (fifo_empty),
      .fifo_full  (fifo_full),
      .capture    (capture),
      .intx_in    (intx_in),
      .win_base   (win_base),
      .win_size   (win_size),
      .win_en     (win_en),
      .pop        (pop),
      .irq_out    (irq_out)
   );

   // R3
   push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !fifo_full && !pop) |=> (fifo_count == $past(fifo_count) + CW'(1)));

   // R1
   capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !pass_valid);

endmodule

// File: tb/tb_msi_capture_ctrl.sv
module tb_msi_capture_ctrl;

   localparam logic [63:0] BASE  = 64'h0000_0001_F000_0000;
   localparam logic [31:0] SIZE  = 32'd4096;
   localparam int          DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [63:0] in_addr;
   logic [31:0] in_data;
   logic        pass_valid;
   logic [63:0] pass_addr;
   logic [31:0] pass_data;
   logic        psel, penable, pwrite;
   logic [11:0] paddr;
   logic [31:0] pwdata, prdata;
   logic [3:0]  intx_in;
   logic        irq_out;

   always #2.5 clk = ~clk;

   msi_capture_ctrl #(.FIFO_DEPTH(DEPTH), .APB_AW(12), .NUM_INTX(4)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
      .pass_valid(pass_valid), .pass_addr(pass_addr), .pass_data(pass_data),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .intx_in(intx_in), .irq_out(irq_out)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   bit en_m = 0;
   bit ovf_m = 0;
   logic [31:0] q_data[$];
   logic [63:0] q_addr[$];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      #1 d = prdata;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   function automatic bit in_win(input logic [63:0] a);
      return en_m && (a >= BASE) && (a < BASE + 64'(SIZE));
   endfunction

   // R1 R2 R6: drive one inbound write, check forwarding, update the model
   task automatic send(input logic [63:0] a, input logic [31:0] d);
      bit hit;
      hit = in_win(a);
      @(negedge clk);
      in_valid = 1; in_addr = a; in_data = d;
      #1;
      chk("R1 pass_valid", pass_valid, !hit);
      if (!hit) chk("R1 pass unchanged", {pass_addr[31:0], pass_data}, {a[31:0], d});
      @(negedge clk);
      in_valid = 0;
      if (hit) begin
         if (q_data.size() < DEPTH) begin
            q_data.push_back(d);
            q_addr.push_back(a);
         end else ovf_m = 1;
      end
   endtask

   function automatic logic [11:0] fld_off(input int f);
      case (f)
         0: return 12'h020;
         1: return 12'h024;
         default: return 12'h028;
      endcase
   endfunction

   // R3 R4 R5: pop the head with one of six read orders
   task automatic pop_check(input int order);
      int p[3];
      logic [31:0] v, v2, st, e;
      case (order % 6)
         0: p = '{0, 1, 2};
         1: p = '{0, 2, 1};
         2: p = '{1, 0, 2};
         3: p = '{1, 2, 0};
         4: p = '{2, 0, 1};
         default: p = '{2, 1, 0};
      endcase
      for (int k = 0; k < 3; k++) begin
         e = (p[k] == 0) ? q_data[0] : (p[k] == 1) ? q_addr[0][31:0] : q_addr[0][63:32];
         apb_rd(fld_off(p[k]), v);
         chk("R3 head field", v, e);
         if (k == 0) begin
            apb_rd(fld_off(p[k]), v2);
            chk("R5 repeat read", v2, e);
         end
         if (k < 2) begin
            apb_rd(12'h018, st);
            chk("R5 not yet popped", st[0], 1'b1);
         end
      end
      void'(q_data.pop_front());
      void'(q_addr.pop_front());
      apb_rd(12'h018, st);
      chk("R4 status after pop", st[1:0], {ovf_m, q_data.size() > 0});
   endtask

   task automatic drain();
      while (q_data.size() > 0) pop_check(int'($urandom % 6));
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd1234));
      rst_n = 0; in_valid = 0; in_addr = '0; in_data = '0;
      psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; intx_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // reset state
      apb_rd(12'h018, r); chk("R4 reset status", r, 0);
      apb_rd(12'h020, r); chk("R7 empty data read", r, 0);
      apb_rd(12'h034, r); chk("R8 reset irq status", r, 0);
      apb_rd(12'h00C, r); chk("R10 reset size", r, 0);
      chk("R9 reset irq_out", irq_out, 0);

      // capture disabled
      apb_wr(12'h004, BASE[31:0]);
      apb_wr(12'h008, BASE[63:32]);
      apb_wr(12'h00C, SIZE);
      send(BASE + 64'd8, 32'd2);
      apb_rd(12'h018, r); chk("R2 disabled no capture", r[0], 0);
      apb_wr(12'h014, 32'hFFFF_FFFF);
      en_m = 1;
      apb_rd(12'h004, r); chk("R10 base lo", r, BASE[31:0]);
      apb_rd(12'h008, r); chk("R10 base hi", r, BASE[63:32]);
      apb_rd(12'h00C, r); chk("R10 size", r, SIZE);
      apb_rd(12'h014, r); chk("R10 enable", r, 1);

      // window boundaries
      send(BASE - 64'd1, 32'h11);
      send(BASE + 64'(SIZE), 32'h22);
      send(BASE + 64'(SIZE) - 64'd1, 32'hABCD);
      send(BASE, 32'd0);
      apb_rd(12'h018, r); chk("R4 non-empty", r[0], 1);
      pop_check(0);
      pop_check(5);

      // random bursts
      for (int rnd = 0; rnd < 8; rnd++) begin
         int nb;
         nb = 1 + int'($urandom % 8);
         for (int i = 0; i < nb; i++) begin
            if ($urandom % 4 == 0) send(BASE + 64'(SIZE) + 64'($urandom % 65536), $urandom);
            else begin
               logic [31:0] vec;
               vec = $urandom % 16;
               send(BASE + 64'(vec) * 4, vec);
            end
         end
         drain();
      end

      // empty reads have no side effect
      apb_rd(12'h024, r); chk("R7 empty addr lo", r, 0);
      apb_rd(12'h028, r); chk("R7 empty addr hi", r, 0);
      send(BASE + 64'd20, 32'd5);
      apb_rd(12'h020, r); chk("R7 data after empty reads", r, 5);
      apb_rd(12'h018, r); chk("R7 no early pop", r[0], 1);
      drain();

      // overflow
      for (int i = 0; i < DEPTH + 1; i++) send(BASE + 64'(i % 16) * 4, 32'(i));
      apb_rd(12'h018, r); chk("R6 overflow flag", r[1:0], 2'b11);
      apb_wr(12'h018, 32'h2);
      ovf_m = 0;
      apb_rd(12'h018, r); chk("R6 overflow cleared", r[1:0], 2'b01);
      chk("R6 entries kept", q_data.size(), DEPTH);
      drain();

      // interrupt masking
      send(BASE + 64'd12, 32'd3);
      repeat (3) @(negedge clk);
      chk("R9 masked irq_out", irq_out, 0);
      apb_rd(12'h034, r); chk("R8 msi status bit", r, 32'h8);
      apb_wr(12'h030, 32'hFFFF_FFFF);
      apb_rd(12'h030, r); chk("R9 enable mask", r, 32'h1E8);
      repeat (2) @(negedge clk);
      chk("R9 irq_out enabled", irq_out, 1);
      apb_wr(12'h034, 32'h8);
      apb_rd(12'h034, r); chk("R8 re-set while pending", r, 32'h8);
      drain();
      apb_wr(12'h034, 32'h8);
      apb_rd(12'h034, r); chk("R8 cleared after drain", r, 0);
      chk("R9 irq_out low", irq_out, 0);
      intx_in = 4'b0100;
      repeat (2) @(negedge clk);
      apb_rd(12'h034, r); chk("R8 intx status", r, 32'h80);
      chk("R9 intx irq_out", irq_out, 1);
      intx_in = 4'b0000;
      apb_wr(12'h034, 32'h80);
      apb_rd(12'h034, r); chk("R8 intx cleared", r, 0);
      apb_wr(12'h030, 32'h8);
      intx_in = 4'b0001;
      repeat (2) @(negedge clk);
      apb_rd(12'h034, r); chk("R8 inta status", r, 32'h20);
      chk("R9 inta masked", irq_out, 0);
      intx_in = 4'b0000;

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule